// File: doc/BRIEF.md
# Aggregated Receive Frame Splitter

This block sits behind a bulk-in receive path where one transfer carries several Ethernet frames packed back to back. Every frame is introduced by a four-byte status word. The block reads the frame length and the error-summary flag from that word. It forwards the frame body without its four trailing CRC bytes as a byte stream with start and end markers. It then discards padding so that the next status word begins on a four-byte boundary, counted from the first byte of the transfer.

Input bytes arrive one per cycle while `in_valid` is high, and `in_last` marks the final byte of a transfer. The block has no backpressure. A decoded status word is reported on the header sideband. A parse problem is reported as a one-cycle fault with a code. After a fault the block discards the rest of the transfer and resumes parsing with the next transfer.

Top module: `rx_frame_splitter`

## Requirements
- R1: A status word is assembled from four bytes, least-significant byte first. `hdr_len` is taken from word bits 29:16 and `hdr_err` from word bit 15. `hdr_valid` pulses for one cycle, one clock after the fourth status byte is accepted.
- R2: For a length L greater than 4, the first L-4 body bytes appear unchanged on `out_data`, each one clock after it is accepted. The first of them has `out_first` set and the last has `out_last` set. The final 4 CRC bytes never appear. When L is 4 or less, no payload is produced and the L bytes are consumed.
- R3: After a frame that does not end on a four-byte boundary relative to the start of the transfer, the padding bytes up to the next boundary are consumed silently. The following status word is then parsed correctly.
- R4: If bit 15 of a status word is set, `fault_valid` pulses with `fault_code` 0 in the same cycle as `hdr_valid`. All following bytes of the transfer produce no payload, header or fault output.
- R5: If the end marker arrives on the first, second or third byte of a status word, `fault_code` 1 is reported and no header is reported.
- R6: If the end marker arrives before a frame body is complete, `fault_code` 2 is reported. This includes the fourth status byte of a word whose length is nonzero.
- R7: A byte whose position in the transfer is MAX_XFER or beyond (default 2560) raises `fault_code` 3. The rest of the transfer is then dropped.
- R8: After any end marker, whether on a good frame or after a fault, the next transfer is parsed from its byte 0 as a status word.
- R9: After reset, `out_valid`, `hdr_valid` and `fault_valid` are low.
- R10: Cycles with `in_valid` low change no state and produce no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input byte present this cycle |
| in_data | input | 8 | Input byte |
| in_last | input | 1 | Final byte of the transfer |
| out_valid | output | 1 | Payload byte valid |
| out_data | output | 8 | Payload byte |
| out_first | output | 1 | First payload byte of a frame |
| out_last | output | 1 | Last payload byte of a frame |
| hdr_valid | output | 1 | Status word decoded |
| hdr_len | output | LEN_W | Frame length from the status word, CRC included |
| hdr_err | output | 1 | Error-summary flag from the status word |
| fault_valid | output | 1 | Parse fault pulse |
| fault_code | output | 2 | 0 error summary, 1 short header, 2 frame too large, 3 transfer too long |

## Verification
The assertions assume that `in_last` only has meaning together with `in_valid`. They also assume that every transfer starts aligned, so byte 0 of each transfer is the first byte of a status word. Given those two points, the padding state can only be reached while the transfer offset is misaligned. The bench keeps within these assumptions: it never raises `in_last` without `in_valid`, and it starts every transfer with a status word. It builds transfers from frames of every length residue modulo four, including lengths 0 to 5. It also places the end marker in the header, in the body, at the CRC edge and past the size limit.

// File: rtl/rsp_pkg.sv
// Shared types and constants for the receive frame splitter.
package rsp_pkg;
    localparam int HDR_BYTES = 4;   // status word size, also the alignment unit
    localparam int CRC_BYTES = 4;   // trailing CRC inside the stated length
    localparam int LEN_LSB   = 16;  // length field low bit in the status word
    localparam int ERR_BIT   = 15;  // error-summary bit in the status word

    typedef enum logic [1:0] {
        FLT_ERRSUM  = 2'd0,
        FLT_SHORT   = 2'd1,
        FLT_LONG    = 2'd2,
        FLT_OVERRUN = 2'd3
    } fault_e;

    typedef enum logic [1:0] {
        ST_HDR, ST_BODY, ST_PAD, ST_DROP
    } state_e;
endpackage

// File: rtl/rsp_offset.sv
// Byte position counter within one transfer.
// Assumes: step is high for every accepted byte; restart marks the final byte.
// Counts up and saturates at MAX_XFER. over is high while the current byte
// position is at or beyond the size limit.
module rsp_offset #(
    parameter int MAX_XFER = 2560,
    localparam int OFF_W   = $clog2(MAX_XFER + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       step,
    input  logic       restart,
    output logic [1:0] align_o,
    output logic       over
);
    logic [OFF_W-1:0] off;

    assign over    = (off >= OFF_W'(MAX_XFER));
    assign align_o = off[1:0];

    // Advance on each byte, clear after the transfer's final byte.
    always_ff @(posedge clk) begin
        if (!rst_n)            off <= '0;
        else if (step) begin
            if (restart)       off <= '0;
            else if (!over)    off <= off + 1'b1;
        end
    end

    p_off_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        off <= OFF_W'(MAX_XFER));
endmodule

// File: rtl/rsp_hdr_asm.sv
// Collects the four status bytes (LSB first) and decodes length and error bit.
// Assumes: take only in the header state; flush on transfer end or abort.
// done is combinational on the fourth byte, so decode is valid that cycle.
module rsp_hdr_asm
    import rsp_pkg::*;
#(
    parameter int LEN_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    input  logic             flush,
    input  logic [7:0]       byte_i,
    output logic             done,
    output logic [LEN_W-1:0] len,
    output logic             err
);
    localparam int IDX_W = $clog2(HDR_BYTES);
    localparam int SH_W  = 8 * (HDR_BYTES - 1);

    logic [IDX_W-1:0] idx;
    logic [SH_W-1:0]  sh;
    logic [8*HDR_BYTES-1:0] word;
    logic unused_hdr_bits;

    assign word = {byte_i, sh};
    assign done = take && (idx == IDX_W'(HDR_BYTES - 1));
    assign len  = word[LEN_LSB +: LEN_W];
    assign err  = word[ERR_BIT];
    assign unused_hdr_bits = ^{word[8*HDR_BYTES-1:LEN_LSB+LEN_W], word[ERR_BIT-1:0]};

    // Byte index and shift register for the partial status word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx <= '0;
            sh  <= '0;
        end else begin
            if (flush || done) idx <= '0;
            else if (take)     idx <= idx + 1'b1;
            if (take)          sh  <= {byte_i, sh[SH_W-1:8]};
        end
    end
endmodule

// File: rtl/rx_frame_splitter.sv
// Splits an aggregated bulk-in transfer into frames.
// Each frame: 4-byte status word, body of stated length (CRC included), then
// padding up to a 4-byte boundary from transfer start. Payload excludes CRC.
// Assumes: in_last only qualified by in_valid; byte 0 of a transfer is a header.
module rx_frame_splitter
    import rsp_pkg::*;
#(
    parameter int MAX_XFER = 2560,
    parameter int LEN_W    = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    input  logic             in_last,
    output logic             out_valid,
    output logic [7:0]       out_data,
    output logic             out_first,
    output logic             out_last,
    output logic             hdr_valid,
    output logic [LEN_W-1:0] hdr_len,
    output logic             hdr_err,
    output logic             fault_valid,
    output logic [1:0]       fault_code
);
    localparam logic [LEN_W-1:0] CRC_L = LEN_W'(CRC_BYTES);

    state_e           st_q, st_d;
    logic [LEN_W-1:0] len_q, len_d, bcnt_q, bcnt_d, pay_len;
    logic [1:0]       align;
    logic             over, hdr_done, hdr_err_w, has_pay, wrap;
    logic [LEN_W-1:0] hdr_len_w;
    logic             emit, e_first, e_last, hdr_p, flt;
    fault_e           flt_c;

    rsp_offset #(.MAX_XFER(MAX_XFER)) u_off (
        .clk(clk), .rst_n(rst_n), .step(in_valid), .restart(in_last),
        .align_o(align), .over(over)
    );

    rsp_hdr_asm #(.LEN_W(LEN_W)) u_hdr (
        .clk(clk), .rst_n(rst_n),
        .take(in_valid && st_q == ST_HDR && !over),
        .flush(in_valid && (in_last || over)),
        .byte_i(in_data), .done(hdr_done), .len(hdr_len_w), .err(hdr_err_w)
    );

    assign has_pay = (len_q > CRC_L);
    assign pay_len = has_pay ? (len_q - CRC_L) : '0;
    assign wrap    = (align == 2'b11);   // next byte lands on a boundary

    // Parse state machine: next state, payload strobes and fault decision.
    always_comb begin
        st_d = st_q; len_d = len_q; bcnt_d = bcnt_q;
        emit = 1'b0; e_first = 1'b0; e_last = 1'b0;
        hdr_p = 1'b0; flt = 1'b0; flt_c = FLT_ERRSUM;
        if (in_valid) begin
            if (st_q != ST_DROP && over) begin
                flt = 1'b1; flt_c = FLT_OVERRUN;
                st_d = in_last ? ST_HDR : ST_DROP;
            end else begin
                case (st_q)
                    ST_HDR: begin
                        if (hdr_done) begin
                            hdr_p = 1'b1; len_d = hdr_len_w; bcnt_d = '0;
                            if (hdr_err_w) begin
                                flt = 1'b1; flt_c = FLT_ERRSUM;
                                st_d = in_last ? ST_HDR : ST_DROP;
                            end else if (hdr_len_w == '0) begin
                                st_d = ST_HDR;
                            end else if (in_last) begin
                                flt = 1'b1; flt_c = FLT_LONG; st_d = ST_HDR;
                            end else begin
                                st_d = ST_BODY;
                            end
                        end else if (in_last) begin
                            flt = 1'b1; flt_c = FLT_SHORT;
                        end
                    end
                    ST_BODY: begin
                        emit    = has_pay && (bcnt_q < pay_len);
                        e_first = emit && (bcnt_q == '0);
                        e_last  = emit && (bcnt_q == pay_len - 1'b1);
                        if (bcnt_q == len_q - 1'b1) begin
                            st_d = (in_last || wrap) ? ST_HDR : ST_PAD;
                        end else if (in_last) begin
                            flt = 1'b1; flt_c = FLT_LONG; st_d = ST_HDR;
                        end else begin
                            bcnt_d = bcnt_q + 1'b1;
                        end
                    end
                    ST_PAD:  if (in_last || wrap) st_d = ST_HDR;
                    default: if (in_last) st_d = ST_HDR;
                endcase
            end
        end
    end

    // State and frame bookkeeping registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_HDR; len_q <= '0; bcnt_q <= '0;
        end else begin
            st_q <= st_d; len_q <= len_d; bcnt_q <= bcnt_d;
        end
    end

    // Registered payload, header and fault outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0; out_data <= '0; out_first <= 1'b0; out_last <= 1'b0;
            hdr_valid <= 1'b0; hdr_len <= '0; hdr_err <= 1'b0;
            fault_valid <= 1'b0; fault_code <= '0;
        end else begin
            out_valid   <= emit;
            out_first   <= e_first;
            out_last    <= e_last;
            hdr_valid   <= hdr_p;
            fault_valid <= flt;
            if (emit)  out_data   <= in_data;
            if (hdr_p) begin hdr_len <= hdr_len_w; hdr_err <= hdr_err_w; end
            if (flt)   fault_code <= flt_c;
        end
    end

    p_pad_misaligned_r3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q == ST_PAD |-> align != 2'b00);
    p_pay_from_body_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(st_q) == ST_BODY);
    p_marks_need_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_first || out_last) |-> out_valid);
    p_quiet_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_DROP && in_valid) |=> (!out_valid && !hdr_valid && !fault_valid));
    p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !hdr_valid && !fault_valid && $stable(st_q)));
endmodule

// File: tb/tb_rx_frame_splitter.sv
module tb_rx_frame_splitter;
    localparam int LEN_W = 14;
    // Vector: [13:0] frame length, [14] end transfer on this frame, [29:16] expected payload.
    localparam logic [31:0] VEC [10] = '{
        {2'd0, 14'd60, 1'b0, 1'b0, 14'd64},
        {2'd0, 14'd1,  1'b0, 1'b0, 14'd5},
        {2'd0, 14'd0,  1'b0, 1'b0, 14'd4},
        {2'd0, 14'd0,  1'b0, 1'b0, 14'd0},
        {2'd0, 14'd0,  1'b0, 1'b0, 14'd1},
        {2'd0, 14'd0,  1'b0, 1'b0, 14'd2},
        {2'd0, 14'd0,  1'b0, 1'b0, 14'd3},
        {2'd0, 14'd3,  1'b0, 1'b0, 14'd7},
        {2'd0, 14'd96, 1'b0, 1'b0, 14'd100},
        {2'd0, 14'd2,  1'b0, 1'b1, 14'd6}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic in_valid = 1'b0, in_last = 1'b0;
    logic [7:0] in_data = '0;
    logic out_valid, out_first, out_last, hdr_valid, hdr_err, fault_valid;
    logic [7:0] out_data;
    logic [LEN_W-1:0] hdr_len;
    logic [1:0] fault_code;

    int checks = 0, errors = 0;
    int n_hdr = 0, n_out = 0, n_first = 0, n_last = 0, n_fault = 0;
    int pay_cnt = 0, data_bad = 0, last_hlen = 0, last_herr = 0, last_code = 0;

    always #4 clk = ~clk;

    rx_frame_splitter #(.MAX_XFER(2560), .LEN_W(LEN_W)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_last(in_last), .out_valid(out_valid), .out_data(out_data),
        .out_first(out_first), .out_last(out_last), .hdr_valid(hdr_valid),
        .hdr_len(hdr_len), .hdr_err(hdr_err), .fault_valid(fault_valid),
        .fault_code(fault_code)
    );

    function automatic logic [7:0] pat(input int len, input int i);
        return 8'((len * 3 + i * 5 + 1) & 8'hff);
    endfunction

    // Monitor at the falling edge, away from the clock edge that updates outputs.
    always @(negedge clk) begin
        if (rst_n) begin
            if (hdr_valid) begin
                n_hdr++; last_hlen = int'(hdr_len); last_herr = int'(hdr_err); pay_cnt = 0;
            end
            if (out_valid) begin
                if (out_data !== pat(last_hlen, pay_cnt)) data_bad++;
                if (out_first !== (pay_cnt == 0)) data_bad++;
                n_out++; pay_cnt++;
                if (out_first) n_first++;
                if (out_last)  n_last++;
            end
            if (fault_valid) begin n_fault++; last_code = int'(fault_code); end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] b, input logic last);
        @(negedge clk); in_valid = 1'b1; in_data = b; in_last = last;
    endtask

    task automatic settle();
        @(negedge clk); in_valid = 1'b0; in_last = 1'b0;
        repeat (2) @(negedge clk);
        #1;
    endtask

    task automatic send_hdr(input int len, input logic es, input logic last);
        logic [31:0] w;
        w = {2'b00, 14'(len), es, 15'd0};
        for (int k = 0; k < 4; k++) send(w[8*k +: 8], last && (k == 3));
    endtask

    // Header, body (payload pattern then CRC filler), then alignment padding.
    task automatic send_frame(input int len, input logic last);
        send_hdr(len, 1'b0, last && (len == 0));
        for (int i = 0; i < len; i++)
            send((i < len - 4) ? pat(len, i) : 8'hC5, last && (i == len - 1));
        if (!last)
            for (int p = 0; p < (4 - len % 4) % 4; p++) send(8'hEE, 1'b0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int h0, f0, l0, o0, fl0;
        repeat (5) @(negedge clk);
        #1;
        // R9: outputs quiet during and right after reset
        chk("R9 out_valid", int'(out_valid), 0);
        chk("R9 hdr_valid", int'(hdr_valid), 0);
        chk("R9 fault_valid", int'(fault_valid), 0);
        @(negedge clk); rst_n = 1'b1;

        // R1 R2 R3: table of frames packed in one transfer
        for (int v = 0; v < 10; v++) begin
            h0 = n_hdr; f0 = n_first; l0 = n_last; fl0 = n_fault;
            send_frame(int'(VEC[v][13:0]), VEC[v][14]);
            settle();
            chk("R1 header count", n_hdr - h0, 1);
            chk("R1 length field", last_hlen, int'(VEC[v][13:0]));
            chk("R2 payload bytes", pay_cnt, int'(VEC[v][29:16]));
            chk("R2 first mark", n_first - f0, (VEC[v][29:16] != 0) ? 1 : 0);
            chk("R2 last mark", n_last - l0, (VEC[v][29:16] != 0) ? 1 : 0);
            chk("R3 no fault", n_fault - fl0, 0);
        end
        chk("R2 payload data", data_bad, 0);

        // R10: idle cycles mid-body change nothing
        send_hdr(12, 1'b0, 1'b0);
        for (int i = 0; i < 3; i++) send(pat(12, i), 1'b0);
        @(negedge clk); in_valid = 1'b0;
        @(negedge clk); o0 = n_out;
        repeat (5) @(negedge clk);
        chk("R10 no output while idle", n_out - o0, 0);
        for (int i = 3; i < 12; i++) send((i < 8) ? pat(12, i) : 8'hC5, i == 11);
        settle();
        chk("R10 frame resumes", pay_cnt, 8);
        chk("R10 data", data_bad, 0);

        // R4: error summary, then the rest of the transfer is dropped
        h0 = n_hdr; fl0 = n_fault; o0 = n_out;
        send_hdr(10, 1'b1, 1'b0);
        send_hdr(8, 1'b0, 1'b0);
        for (int i = 0; i < 5; i++) send(8'h11, i == 4);
        settle();
        chk("R4 error flag", last_herr, 1);
        chk("R4 one header", n_hdr - h0, 1);
        chk("R4 one fault", n_fault - fl0, 1);
        chk("R4 code", last_code, 0);
        chk("R4 nothing forwarded", n_out - o0, 0);

        // R8: next transfer parses from byte 0
        send_frame(9, 1'b1);
        settle();
        chk("R8 length", last_hlen, 9);
        chk("R8 payload", pay_cnt, 5);

        // R5: transfer ends on the second status byte
        h0 = n_hdr; fl0 = n_fault;
        send(8'h00, 1'b0); send(8'h00, 1'b1);
        settle();
        chk("R5 fault", n_fault - fl0, 1);
        chk("R5 code", last_code, 1);
        chk("R5 no header", n_hdr - h0, 0);

        // R6: transfer ends inside a body
        fl0 = n_fault;
        send_hdr(20, 1'b0, 1'b0);
        for (int i = 0; i < 10; i++) send(pat(20, i), i == 9);
        settle();
        chk("R6 body fault", n_fault - fl0, 1);
        chk("R6 body code", last_code, 2);
        chk("R6 partial payload", pay_cnt, 10);

        // R6: transfer ends on the last status byte with nonzero length
        fl0 = n_fault;
        send_hdr(8, 1'b0, 1'b1);
        settle();
        chk("R6 header-end fault", n_fault - fl0, 1);
        chk("R6 header-end code", last_code, 2);

        // R7: byte beyond the transfer size limit
        fl0 = n_fault;
        send_frame(2556, 1'b0);
        for (int i = 0; i < 3; i++) send(8'h22, i == 2);
        settle();
        chk("R7 payload before limit", pay_cnt, 2552);
        chk("R7 fault", n_fault - fl0, 1);
        chk("R7 code", last_code, 3);
        chk("R7 data", data_bad, 0);

        // R8: recovery after overrun
        send_frame(5, 1'b1);
        settle();
        chk("R8 after overrun length", last_hlen, 5);
        chk("R8 after overrun payload", pay_cnt, 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule